// File: doc/BRIEF.md
# Gated Counter Gate-Control Unit

This block is a 16-bit up-counter whose counting is qualified by an external, asynchronous gate signal. The gate is synchronized, given a selectable polarity, and then shaped by one of four gate modes. Plain level gating counts while the gate is active. Toggle mode counts over a whole gate period. Single-pulse mode is armed by software and counts over exactly one active pulse. The two modes can be combined to count over exactly one whole period. A count tick, supplied by a prescaler outside the block, decides in which cycles the counter may advance.

Software reads the effective gate level at any time, and it can load or read the counter through a plain port. It sees two sticky interrupt flags. One is raised when the effective gate level falls. The other is raised when the counter wraps. Each flag has its own enable, and together they drive a single interrupt line.

Top module: `gated_count_ctl`

## Requirements
- R1: After reset the counter is 0000h, both interrupt flags, `go_busy` and `irq` are 0, and with `ctl_pol`=1 and `gate_in` low `gate_val` is 0.
- R2: On a rising clock edge the counter advances by one exactly when `ctl_on`=1, `tick`=1 and either `ctl_gate_en`=0 or `gate_val`=1. Otherwise it holds.
- R3: When `cnt_wr`=1 the counter takes `cnt_wdata` on that edge, even if an increment would also occur.
- R4: Incrementing from FFFFh gives 0000h and sets `roll_if`. The flag stays set until a cycle with `rif_clr`=1.
- R5: In level mode (`ctl_toggle`=0, `ctl_sp_en`=0) the counter advances once per cycle of active gate level. With `ctl_pol`=1 the active level is high; with `ctl_pol`=0 it is low.
- R6: In toggle mode each active gate edge flips an internal stage, so the counter runs for whole gate periods. While `ctl_toggle`=0 that stage is held at 0, so toggle mode always resumes with the stage at 0.
- R7: In single-pulse mode a `go_set` pulse sets `go_busy`. Counting starts at the next active gate edge, and `go_busy` clears by itself at the following trailing edge. After that no gate activity advances the counter until `go_busy` is set again.
- R8: While `ctl_sp_en`=0, `go_busy` is 0 one cycle later, and a `go_set` pulse has no effect.
- R9: With toggle and single-pulse both on, one arm counts exactly one whole gate period (active time plus inactive time).
- R10: `gate_val` gives the effective gate level even when `ctl_gate_en`=0. In level mode it follows a change of `gate_in` after the third rising clock edge.
- R11: A falling edge of `gate_val` sets `gate_if` one cycle later, whatever the value of `ctl_gate_en`. The flag stays set until a cycle with `gif_clr`=1.
- R12: `irq` = (`gate_if` AND `gie`) OR (`roll_if` AND `rie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count-enable strobe |
| gate_in | input | 1 | Asynchronous gate signal |
| ctl_on | input | 1 | Counter run enable |
| ctl_gate_en | input | 1 | 1: counting qualified by the gate |
| ctl_pol | input | 1 | 1: gate active high, 0: active low |
| ctl_toggle | input | 1 | Toggle (whole-period) mode |
| ctl_sp_en | input | 1 | Single-pulse mode enable |
| go_set | input | 1 | One-cycle pulse that arms single-pulse capture |
| gif_clr | input | 1 | Clears the gate interrupt flag |
| rif_clr | input | 1 | Clears the rollover interrupt flag |
| gie | input | 1 | Gate interrupt enable |
| rie | input | 1 | Rollover interrupt enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| cnt_q | output | 16 | Counter value |
| go_busy | output | 1 | Single-pulse armed/in-progress status |
| gate_val | output | 1 | Effective gate control level |
| gate_if | output | 1 | Sticky gate-event interrupt flag |
| roll_if | output | 1 | Sticky rollover interrupt flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `go_set` does not arrive in the same cycle as a single-pulse trailing edge, and that `ctl_pol` and `ctl_toggle` are not changed together while the gate is active. The bench keeps to these assumptions. It changes mode and polarity bits only while the gate is idle, and it arms capture several cycles before the first pulse. The gate-mode sweeps cover active and inactive widths from one to four cycles, so synchronizer latency never hides a pulse. The expected counts are computed from those widths.

// File: rtl/gcu_pkg.sv
package gcu_pkg;
    typedef struct packed {
        logic g_q;     // registered polarized gate
        logic tff;     // toggle stage
        logic lvl_q;   // registered mode-shaped level
        logic go;      // single-pulse armed
        logic run;     // single-pulse window open
        logic eff_q;   // registered effective level
        logic gif;     // gate event flag
    } gate_st_t;
endpackage

// File: rtl/gcu_gate_sync.sv
module gcu_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic pol,
    output logic g
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = gate_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], gate_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign g = pol ? sh_q[STAGES-1] : ~sh_q[STAGES-1];
endmodule

// File: rtl/gcu_gate_path.sv
module gcu_gate_path
    import gcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic g,
    input  logic toggle,
    input  logic sp_en,
    input  logic go_set,
    input  logic gif_clr,
    output logic gate_val,
    output logic go,
    output logic gif
);
    gate_st_t st_d, st_q;
    logic lvl, g_rise, lvl_rise, lvl_fall, eff;

    always_comb begin
        lvl      = toggle ? st_q.tff : st_q.g_q;
        g_rise   = g & ~st_q.g_q;
        lvl_rise = lvl & ~st_q.lvl_q;
        lvl_fall = ~lvl & st_q.lvl_q;
        eff      = sp_en ? (st_q.go & lvl & (st_q.run | lvl_rise)) : lvl;

        st_d       = st_q;
        st_d.g_q   = g;
        st_d.tff   = toggle ? (st_q.tff ^ g_rise) : 1'b0;
        st_d.lvl_q = lvl;
        st_d.run   = sp_en & eff;
        if (!sp_en)                     st_d.go = 1'b0;
        else if (go_set)                st_d.go = 1'b1;
        else if (st_q.run && lvl_fall)  st_d.go = 1'b0;
        st_d.eff_q = eff;
        st_d.gif   = (st_q.gif & ~gif_clr) | (st_q.eff_q & ~eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate_val = eff;
    assign go       = st_q.go;
    assign gif      = st_q.gif;

    p_tff_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle |=> !st_q.tff);
    p_go_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sp_en |=> !go);
    p_trail_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_en && st_q.run && lvl_fall && !go_set) |=> !go);
    p_sp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_en && !go) |-> !gate_val);
    p_gate_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.eff_q && !gate_val) |=> gif);
endmodule

// File: rtl/gcu_count.sv
module gcu_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rif_clr,
    output logic [W-1:0] cnt,
    output logic         rif
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         rif;
    } cnt_st_t;

    cnt_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr)       c_d.cnt = wdata;
        else if (inc) c_d.cnt = c_q.cnt + 1'b1;
        c_d.rif = (c_q.rif & ~rif_clr) | (~wr & inc & (&c_q.cnt));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
    assign rif = c_q.rif;

    p_wr_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt == $past(wdata));
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && inc && (&cnt)) |=> (cnt == '0) && rif);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/gated_count_ctl.sv
module gated_count_ctl #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate_in,
    input  logic             ctl_on,
    input  logic             ctl_gate_en,
    input  logic             ctl_pol,
    input  logic             ctl_toggle,
    input  logic             ctl_sp_en,
    input  logic             go_set,
    input  logic             gif_clr,
    input  logic             rif_clr,
    input  logic             gie,
    input  logic             rie,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             go_busy,
    output logic             gate_val,
    output logic             gate_if,
    output logic             roll_if,
    output logic             irq
);
    logic g_pol, inc;

    gcu_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .pol(ctl_pol), .g(g_pol)
    );

    gcu_gate_path u_path (
        .clk(clk), .rst_n(rst_n), .g(g_pol), .toggle(ctl_toggle),
        .sp_en(ctl_sp_en), .go_set(go_set), .gif_clr(gif_clr),
        .gate_val(gate_val), .go(go_busy), .gif(gate_if)
    );

    assign inc = ctl_on & tick & (~ctl_gate_en | gate_val);

    gcu_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr(cnt_wr), .wdata(cnt_wdata),
        .rif_clr(rif_clr), .cnt(cnt_q), .rif(roll_if)
    );

    assign irq = (gate_if & gie) | (roll_if & rie);

    p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_on && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: tb/gated_count_ctl_tb.sv
module gated_count_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, gate_in = 1'b0, ctl_on = 1'b0, ctl_gate_en = 1'b0;
    logic ctl_pol = 1'b1, ctl_toggle = 1'b0, ctl_sp_en = 1'b0, go_set = 1'b0;
    logic gif_clr = 1'b0, rif_clr = 1'b0, gie = 1'b0, rie = 1'b0, cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] cnt_q;
    logic go_busy, gate_val, gate_if, roll_if, irq;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gated_count_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in), .ctl_on(ctl_on),
        .ctl_gate_en(ctl_gate_en), .ctl_pol(ctl_pol), .ctl_toggle(ctl_toggle),
        .ctl_sp_en(ctl_sp_en), .go_set(go_set), .gif_clr(gif_clr), .rif_clr(rif_clr),
        .gie(gie), .rie(rie), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .go_busy(go_busy), .gate_val(gate_val), .gate_if(gate_if),
        .roll_if(roll_if), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; step(1); cnt_wr = 1'b0;
    endtask

    // mode[0] toggle, mode[1] single-pulse
    task automatic run_mode(input int mode, input int h, input int l);
        int npulse, exp;
        string req;
        ctl_toggle = 1'b0; ctl_sp_en = 1'b0; step(3);
        ctl_toggle = mode[0]; ctl_sp_en = mode[1]; step(2);
        load(16'h0000);
        if (mode[1]) begin
            go_set = 1'b1; step(1); go_set = 1'b0; step(2);
            check("R7 armed", {31'd0, go_busy}, 32'd1);
        end
        npulse = mode[1] ? 3 : 2;
        for (int p = 0; p < npulse; p++) begin
            gate_in = 1'b1; step(h);
            gate_in = 1'b0; step(l);
        end
        step(8);
        case (mode)
            0: begin exp = 2 * h;  req = "R5 level"; end
            1: begin exp = h + l;  req = "R6 toggle"; end
            2: begin exp = h;      req = "R7 single-pulse"; end
            default: begin exp = h + l; req = "R9 toggle+single-pulse"; end
        endcase
        check(req, {16'd0, cnt_q}, exp);
        if (mode[1]) check("R7 go cleared", {31'd0, go_busy}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 cnt", {16'd0, cnt_q}, 0);
        check("R1 flags", {28'd0, go_busy, gate_if, roll_if, irq}, 0);
        check("R1 gate_val", {31'd0, gate_val}, 0);

        // R2 on=0 holds, ticks counted when gate disabled
        tick = 1'b1; step(10);
        check("R2 off holds", {16'd0, cnt_q}, 0);
        ctl_on = 1'b1;
        for (int i = 0; i < 20; i++) begin tick = i[0]; step(1); end
        tick = 1'b0; step(2);
        check("R2 tick count", {16'd0, cnt_q}, 10);

        // R3 write beats increment
        tick = 1'b1; load(16'h1234); tick = 1'b0;
        check("R3 write priority", {16'd0, cnt_q}, 16'h1234);

        // R4 wrap and sticky rollover flag, R12 irq
        load(16'hFFFE); tick = 1'b1; step(2); tick = 1'b0;
        check("R4 wrap value", {16'd0, cnt_q}, 0);
        check("R4 flag set", {31'd0, roll_if}, 1);
        step(5);
        check("R4 flag sticky", {31'd0, roll_if}, 1);
        check("R12 irq masked", {31'd0, irq}, 0);
        rie = 1'b1; step(1);
        check("R12 irq rollover", {31'd0, irq}, 1);
        rif_clr = 1'b1; step(1); rif_clr = 1'b0;
        check("R4 flag cleared", {31'd0, roll_if}, 0);
        check("R12 irq drops", {31'd0, irq}, 0);
        rie = 1'b0;

        // R10 gate_val latency with gate disabled, R11 gate flag
        gate_in = 1'b1; step(2);
        check("R10 not yet", {31'd0, gate_val}, 0);
        step(1);
        check("R10 follows", {31'd0, gate_val}, 1);
        gate_in = 1'b0; step(3);
        check("R10 falls", {31'd0, gate_val}, 0);
        check("R11 not yet", {31'd0, gate_if}, 0);
        step(1);
        check("R11 set", {31'd0, gate_if}, 1);
        step(10);
        check("R11 sticky", {31'd0, gate_if}, 1);
        gie = 1'b1; step(1);
        check("R12 irq gate", {31'd0, irq}, 1);
        gif_clr = 1'b1; step(1); gif_clr = 1'b0;
        check("R11 cleared", {31'd0, gate_if}, 0);
        gie = 1'b0;

        // gate-qualified mode sweeps (R5, R6, R7, R9)
        ctl_gate_en = 1'b1; tick = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int h = 1; h <= 4; h++)
                for (int l = 1; l <= 4; l++)
                    run_mode(m, h, l);
        ctl_toggle = 1'b0; ctl_sp_en = 1'b0; step(3);

        // R6 toggle stage forced to 0 while disabled
        ctl_toggle = 1'b1; step(2);
        gate_in = 1'b1; step(2); gate_in = 1'b0; step(6);
        check("R6 stage set", {31'd0, gate_val}, 1);
        ctl_toggle = 1'b0; step(2);
        check("R6 off level", {31'd0, gate_val}, 0);
        ctl_toggle = 1'b1; step(2);
        check("R6 resumes at 0", {31'd0, gate_val}, 0);
        ctl_toggle = 1'b0; step(2);

        // R8 clearing single-pulse enable drops go
        ctl_sp_en = 1'b1; step(1);
        go_set = 1'b1; step(1); go_set = 1'b0; step(1);
        check("R8 armed", {31'd0, go_busy}, 1);
        ctl_sp_en = 1'b0; step(1);
        check("R8 go dropped", {31'd0, go_busy}, 0);
        go_set = 1'b1; step(1); go_set = 1'b0; step(1);
        check("R8 go ignored", {31'd0, go_busy}, 0);

        // R5 active-low polarity
        gate_in = 1'b1; step(4);
        ctl_pol = 1'b0; step(4);
        load(16'h0000);
        gate_in = 1'b0; step(5);
        gate_in = 1'b1; step(8);
        check("R5 active low", {16'd0, cnt_q}, 5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule